// File: doc/BRIEF.md
# Low-Power State Sequencer with Qualified Wakeup

This block decides which of three power states a small processor subsystem is in: Operating (CPU clocked), Idle (CPU clock gated, everything else alive) and Standby (main clock and PLL off). Software moves it down with single-cycle halt and standby strobes. Interrupts, a keyboard scan and an external wakeup pin move it back up. A power-fail or user-reset condition pushes it into Standby from anywhere. A short warm-up state between Standby and Operating turns the PLL on first and keeps the CPU clock off for a fixed number of main clocks. It holds the CPU in reset only when the Standby was forced or followed a power-on reset.

The wakeup pin goes through a synchronizer and a slow-tick hold filter. It is ignored during a blanking window after power-on reset. Leaving Standby is also gated by the power-status inputs. The keyboard source is either a debounced OR of all columns or a raw OR of the narrower column group. A direct-wake control lets a keypress wake the device even when the keyboard interrupt is masked. All interfaces are plain control and status levels or strobes. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset the block is in Standby with run, cpu_clk_en, pll_en and cpu_rst_n all low. run is high only in Operating and Idle, cpu_clk_en only in Operating, and pll_en is low only in Standby.
- R2: In Operating, a halt strobe enters Idle and a standby strobe enters Standby. If both strobes arrive in the same cycle, Standby wins.
- R3: In Idle, any pending interrupt whose enable bit is set, or an active keyboard wake, returns to Operating. A pending interrupt that is not enabled has no effect.
- R4: The wakeup pin has no effect in Operating or Idle.
- R5: power_fail or user_reset forces Standby from Operating or Idle and drives cpu_rst_n low.
- R6: After a power-on or forced Standby, only an accepted wakeup leaves Standby. Interrupts and keyboard activity are ignored.
- R7: After a software-entered Standby, an accepted wakeup or an enabled pending interrupt leaves Standby, and cpu_rst_n stays high throughout. An interrupt whose bit is set in NOWAKE_MASK never wakes from Standby. The default mask covers bits 0, 1 and 2.
- R8: Leaving Standby happens only when power_fail is low and ext_pwr or batt_ok is high. A wake event that arrives while this condition is false is discarded.
- R9: A wakeup is accepted only after the synchronized pin has stayed high for HOLD_TICKS slow ticks. The pin must return low before a further wakeup can be accepted.
- R10: The wakeup pin is ignored for the first BLANK_TICKS slow ticks after reset is released.
- R11: On leaving Standby, pll_en rises first. cpu_clk_en and run rise exactly SETTLE_CLKS main clocks later. cpu_rst_n is released in that same cycle.
- R12: With kbd_six_col set, kbd_irq follows the OR of columns 0 to 5 one clock later without debounce, and columns 6 and 7 have no effect. With it clear, kbd_irq rises only after any of the 8 columns has stayed active for KDEB_TICKS slow ticks, and it falls one clock after all columns go low.
- R13: A keyboard event wakes or un-idles the device only when kbd_irq_en is set or kbd_direct_wake is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on main clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| slow_tick | input | 1 | One-cycle pulse at the slow-clock rate |
| halt_req | input | 1 | Single-cycle strobe: enter Idle |
| stby_req | input | 1 | Single-cycle strobe: enter Standby |
| irq_pend | input | IRQ_W | Pending interrupt vector |
| irq_en | input | IRQ_W | Interrupt enable vector |
| wake_pin | input | 1 | External wakeup pin, asynchronous |
| power_fail | input | 1 | Power-fail condition, active high |
| ext_pwr | input | 1 | External supply present |
| batt_ok | input | 1 | Battery voltage adequate |
| user_reset | input | 1 | User reset request, active high |
| kbd_col | input | KBD_COLS | Keyboard column inputs |
| kbd_six_col | input | 1 | Use only the narrow column group, raw |
| kbd_irq_en | input | 1 | Keyboard interrupt enable |
| kbd_direct_wake | input | 1 | Keypress wakes regardless of enable |
| run | output | 1 | High in Operating and Idle |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_rst_n | output | 1 | CPU reset, active low |
| pll_en | output | 1 | PLL enable |
| kbd_irq | output | 1 | Keyboard interrupt request |

## Verification
The bench uses a scaled configuration and goes after the edges of the standby exit. It sweeps all eight power-input combinations, where a design with a wrong gate would wake on battery-low or ignore external power. It sweeps every interrupt bit in both Idle and Standby, where a design that ignored NOWAKE_MASK would wake from Standby on a tick source. It applies interrupts after a cold Standby, where a missing cold flag would let them wake the device. It drives a wakeup pulse one tick too short and one inside the blanking window, both of which a weak filter would accept. It counts the warm-up exactly, sweeps every keyboard column in both column modes, and pairs each keyboard mask setting with direct wake.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    PS_STBY = 2'd0,
    PS_WARM = 2'd1,
    PS_OPER = 2'd2,
    PS_IDLE = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pss_wake_filter.sv
module pss_wake_filter #(
  parameter int HOLD_TICKS  = 4096,
  parameter int BLANK_TICKS = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic accept
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int BW = $clog2(BLANK_TICKS + 1);

  logic [1:0]    sync_q;
  logic [HW-1:0] hold_cnt;
  logic [BW-1:0] blank_cnt;
  logic          qual, qual_q, blank_done;

  assign blank_done = (blank_cnt == BW'(BLANK_TICKS));
  assign qual       = (hold_cnt == HW'(HOLD_TICKS));
  assign accept     = qual & ~qual_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= '0;
      hold_cnt  <= '0;
      blank_cnt <= '0;
      qual_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin};
      qual_q <= qual;
      if (tick && !blank_done) blank_cnt <= blank_cnt + 1'b1;
      if (!sync_q[1] || !blank_done) hold_cnt <= '0;
      else if (tick && !qual) hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pss_kbd_wake.sv
module pss_kbd_wake #(
  parameter int COLS      = 8,
  parameter int NARROW    = 6,
  parameter int DEB_TICKS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [COLS-1:0] col,
  input  logic            six_col,
  input  logic            irq_en,
  input  logic            direct,
  output logic            irq,
  output logic            wake
);
  localparam int DW = $clog2(DEB_TICKS + 1);

  logic          any_wide, any_narrow, raw_q, deb_hit;
  logic [DW-1:0] deb_cnt;

  assign any_wide = |col;

  generate
    if (NARROW < COLS) begin : g_narrow
      assign any_narrow = |col[NARROW-1:0];
    end else begin : g_full
      assign any_narrow = any_wide;
    end
  endgenerate

  assign deb_hit = (deb_cnt == DW'(DEB_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deb_cnt <= '0;
      raw_q   <= 1'b0;
    end else begin
      raw_q <= any_narrow;
      if (!any_wide) deb_cnt <= '0;
      else if (tick && !deb_hit) deb_cnt <= deb_cnt + 1'b1;
    end
  end

  assign irq  = six_col ? raw_q : deb_hit;
  assign wake = irq & (irq_en | direct);
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int               IRQ_W       = 8,
  parameter logic [IRQ_W-1:0] NOWAKE_MASK = 8'h07,
  parameter int               HOLD_TICKS  = 4096,
  parameter int               BLANK_TICKS = 65536,
  parameter int               KDEB_TICKS  = 16,
  parameter int               SETTLE_CLKS = 8,
  parameter int               KBD_COLS    = 8,
  parameter int               KBD_NARROW  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slow_tick,
  input  logic                halt_req,
  input  logic                stby_req,
  input  logic [IRQ_W-1:0]    irq_pend,
  input  logic [IRQ_W-1:0]    irq_en,
  input  logic                wake_pin,
  input  logic                power_fail,
  input  logic                ext_pwr,
  input  logic                batt_ok,
  input  logic                user_reset,
  input  logic [KBD_COLS-1:0] kbd_col,
  input  logic                kbd_six_col,
  input  logic                kbd_irq_en,
  input  logic                kbd_direct_wake,
  output logic                run,
  output logic                cpu_clk_en,
  output logic                cpu_rst_n,
  output logic                pll_en,
  output logic                kbd_irq
);
  localparam int SW = $clog2(SETTLE_CLKS + 1);

  pwr_state_e    state_q, state_d;
  logic          cold_q, cold_d;
  logic [SW-1:0] settle_cnt;
  logic          wake_acc, kbd_wake;
  logic          forced, pwr_ok, irq_any, irq_stby, stby_exit;

  pss_wake_filter #(
    .HOLD_TICKS (HOLD_TICKS),
    .BLANK_TICKS(BLANK_TICKS)
  ) wake_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (slow_tick),
    .pin   (wake_pin),
    .accept(wake_acc)
  );

  pss_kbd_wake #(
    .COLS     (KBD_COLS),
    .NARROW   (KBD_NARROW),
    .DEB_TICKS(KDEB_TICKS)
  ) kbd_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (slow_tick),
    .col    (kbd_col),
    .six_col(kbd_six_col),
    .irq_en (kbd_irq_en),
    .direct (kbd_direct_wake),
    .irq    (kbd_irq),
    .wake   (kbd_wake)
  );

  assign forced    = power_fail | user_reset;
  assign pwr_ok    = ~power_fail & (ext_pwr | batt_ok);
  assign irq_any   = (|(irq_pend & irq_en)) | kbd_wake;
  assign irq_stby  = (|(irq_pend & irq_en & ~NOWAKE_MASK)) | kbd_wake;
  assign stby_exit = pwr_ok & ~user_reset & (wake_acc | (~cold_q & irq_stby));

  always_comb begin
    state_d = state_q;
    cold_d  = cold_q;
    unique case (state_q)
      PS_STBY: begin
        if (user_reset) cold_d = 1'b1;
        else if (stby_exit) state_d = PS_WARM;
      end
      PS_WARM: begin
        if (forced) begin
          state_d = PS_STBY;
          cold_d  = 1'b1;
        end else if (settle_cnt == SW'(SETTLE_CLKS - 1)) begin
          state_d = PS_OPER;
          cold_d  = 1'b0;
        end
      end
      PS_OPER: begin
        if (forced) begin
          state_d = PS_STBY;
          cold_d  = 1'b1;
        end else if (stby_req) state_d = PS_STBY;
        else if (halt_req) state_d = PS_IDLE;
      end
      PS_IDLE: begin
        if (forced) begin
          state_d = PS_STBY;
          cold_d  = 1'b1;
        end else if (irq_any) state_d = PS_OPER;
      end
      default: state_d = PS_STBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= PS_STBY;
      cold_q     <= 1'b1;
      settle_cnt <= '0;
    end else begin
      state_q <= state_d;
      cold_q  <= cold_d;
      if (state_q == PS_WARM) settle_cnt <= settle_cnt + 1'b1;
      else settle_cnt <= '0;
    end
  end

  assign run        = (state_q == PS_OPER) | (state_q == PS_IDLE);
  assign cpu_clk_en = (state_q == PS_OPER);
  assign pll_en     = (state_q != PS_STBY);
  assign cpu_rst_n  = ~cold_q;
endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk #(
  parameter int IRQ_W      = 8,
  parameter int KBD_COLS   = 8,
  parameter int KBD_NARROW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                halt_req,
  input logic                stby_req,
  input logic [IRQ_W-1:0]    irq_pend,
  input logic [IRQ_W-1:0]    irq_en,
  input logic                power_fail,
  input logic                ext_pwr,
  input logic                batt_ok,
  input logic                user_reset,
  input logic [KBD_COLS-1:0] kbd_col,
  input logic                kbd_six_col,
  input logic                run,
  input logic                cpu_clk_en,
  input logic                cpu_rst_n,
  input logic                pll_en,
  input logic                kbd_irq
);
  // R1
  clk_en_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (run && pll_en));

  // R1
  run_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pll_en);

  // R2
  halt_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && halt_req && !stby_req && !power_fail && !user_reset)
      |=> (run && !cpu_clk_en));

  // R2
  stby_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && stby_req && !power_fail && !user_reset) |=> !pll_en);

  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cpu_clk_en && !(|(irq_pend & irq_en)) && !kbd_irq
      && !power_fail && !user_reset) |=> (run && !cpu_clk_en));

  // R5
  forced_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (power_fail || user_reset)) |=> (!run && !pll_en && !cpu_rst_n));

  // R8
  exit_power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(!power_fail && (ext_pwr || batt_ok)));

  // R11
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> (cpu_clk_en && $rose(cpu_clk_en)));

  // R12
  six_col_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_six_col |-> (kbd_irq == $past(|kbd_col[KBD_NARROW-1:0])));
endmodule

bind pwr_state_seq pwr_state_seq_chk #(
  .IRQ_W     (IRQ_W),
  .KBD_COLS  (KBD_COLS),
  .KBD_NARROW(KBD_NARROW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_req   (halt_req),
  .stby_req   (stby_req),
  .irq_pend   (irq_pend),
  .irq_en     (irq_en),
  .power_fail (power_fail),
  .ext_pwr    (ext_pwr),
  .batt_ok    (batt_ok),
  .user_reset (user_reset),
  .kbd_col    (kbd_col),
  .kbd_six_col(kbd_six_col),
  .run        (run),
  .cpu_clk_en (cpu_clk_en),
  .cpu_rst_n  (cpu_rst_n),
  .pll_en     (pll_en),
  .kbd_irq    (kbd_irq)
);

// File: tb/pwr_state_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_state_seq_tb_top;
  localparam int       IRQ_W  = 8;
  localparam int       HOLD   = 4;
  localparam int       BLANK  = 6;
  localparam int       KDEB   = 3;
  localparam int       SETTLE = 8;
  localparam int       TPER   = 4;
  localparam logic [7:0] NOWAKE = 8'h07;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0;
  logic halt_req = 0, stby_req = 0, wake_pin = 0;
  logic power_fail = 0, ext_pwr = 1, batt_ok = 1, user_reset = 0;
  logic [IRQ_W-1:0] irq_pend = '0, irq_en = '0;
  logic [7:0] kbd_col = '0;
  logic kbd_six_col = 0, kbd_irq_en = 0, kbd_direct_wake = 0;
  logic run, cpu_clk_en, cpu_rst_n, pll_en, kbd_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_state_seq #(
    .IRQ_W(IRQ_W), .NOWAKE_MASK(NOWAKE), .HOLD_TICKS(HOLD),
    .BLANK_TICKS(BLANK), .KDEB_TICKS(KDEB), .SETTLE_CLKS(SETTLE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .halt_req(halt_req), .stby_req(stby_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .wake_pin(wake_pin),
    .power_fail(power_fail), .ext_pwr(ext_pwr), .batt_ok(batt_ok),
    .user_reset(user_reset), .kbd_col(kbd_col), .kbd_six_col(kbd_six_col),
    .kbd_irq_en(kbd_irq_en), .kbd_direct_wake(kbd_direct_wake),
    .run(run), .cpu_clk_en(cpu_clk_en), .cpu_rst_n(cpu_rst_n),
    .pll_en(pll_en), .kbd_irq(kbd_irq)
  );

  initial forever begin
    repeat (TPER - 1) @(negedge clk);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse(input int ticks);
    wake_pin = 1'b1;
    cyc(ticks * TPER);
    wake_pin = 1'b0;
    cyc(4);
  endtask

  task automatic strobe_halt();
    halt_req = 1'b1; cyc(1); halt_req = 1'b0; cyc(1);
  endtask

  task automatic strobe_stby();
    stby_req = 1'b1; cyc(1); stby_req = 1'b0; cyc(1);
  endtask

  task automatic strobe_ureset();
    user_reset = 1'b1; cyc(1); user_reset = 1'b0; cyc(1);
  endtask

  task automatic full_wake();
    pin_pulse(HOLD + 2);
    cyc(SETTLE + 2);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 run", run, 1'b0);
    chk("R1 pll_en", pll_en, 1'b0);
    chk("R1 cpu_clk_en", cpu_clk_en, 1'b0);
    chk("R1 cpu_rst_n", cpu_rst_n, 1'b0);

    // R10 wakeup inside blanking window ignored
    wake_pin = 1'b1;
    cyc((BLANK - 1) * TPER - 2);
    wake_pin = 1'b0;
    cyc(4 * TPER);
    chk("R10 blank", pll_en, 1'b0);

    // R6 cold standby ignores interrupts and keyboard
    irq_pend = '1; irq_en = '1;
    kbd_six_col = 1'b1; kbd_direct_wake = 1'b1; kbd_col = 8'h01;
    cyc(3 * TPER);
    chk("R6 cold irq", pll_en, 1'b0);
    irq_pend = '0; irq_en = '0; kbd_col = '0; kbd_direct_wake = 1'b0;
    cyc(2);

    // R9 pulse one tick short
    wake_pin = 1'b1;
    cyc((HOLD - 1) * TPER);
    wake_pin = 1'b0;
    cyc(3 * TPER);
    chk("R9 short", pll_en, 1'b0);

    // R8 sweep of power inputs
    for (int i = 0; i < 8; i++) begin
      logic exp_run;
      power_fail = i[2]; ext_pwr = i[1]; batt_ok = i[0];
      exp_run = !i[2] && (i[1] || i[0]);
      full_wake();
      chk($sformatf("R8 pwr=%0d", i), run, exp_run);
      power_fail = 1'b0; ext_pwr = 1'b1; batt_ok = 1'b1;
      strobe_ureset();
      chk("R5 ureset", run, 1'b0);
    end

    // R11 exact warm-up length
    begin
      int k = 0, n = 0;
      wake_pin = 1'b1;
      while (!pll_en && k < 200) begin @(negedge clk); k++; end
      chk("R11 pll first", cpu_clk_en, 1'b0);
      chk("R11 rst held", cpu_rst_n, 1'b0);
      while (!cpu_clk_en && n < 60) begin @(negedge clk); n++; end
      chk("R11 settle count", n == SETTLE, 1'b1);
      chk("R11 rst release", cpu_rst_n, 1'b1);
      chk("R11 run", run, 1'b1);
      cyc(HOLD * TPER);
      wake_pin = 1'b0;
      cyc(4);
    end

    // R4 wakeup in Operating
    pin_pulse(HOLD + 2);
    chk("R4 oper", cpu_clk_en, 1'b1);

    // R2 halt, R4 wakeup in Idle, R3 masked pending
    strobe_halt();
    chk("R2 idle run", run, 1'b1);
    chk("R2 idle clk", cpu_clk_en, 1'b0);
    pin_pulse(HOLD + 2);
    chk("R4 idle", cpu_clk_en, 1'b0);
    irq_pend = 8'h08; cyc(3);
    chk("R3 masked", cpu_clk_en, 1'b0);
    irq_pend = '0; cyc(1);

    // R3 every interrupt bit exits Idle
    for (int b = 0; b < IRQ_W; b++) begin
      strobe_halt();
      irq_pend = 8'(1 << b); irq_en = 8'(1 << b);
      cyc(2);
      chk($sformatf("R3 bit%0d", b), cpu_clk_en, 1'b1);
      irq_pend = '0; irq_en = '0; cyc(1);
    end

    // R2 both strobes: standby wins, software standby keeps CPU out of reset
    halt_req = 1'b1; stby_req = 1'b1; cyc(1);
    halt_req = 1'b0; stby_req = 1'b0; cyc(1);
    chk("R2 both pll", pll_en, 1'b0);
    chk("R7 rst kept", cpu_rst_n, 1'b1);

    // R7 masked pending does not wake
    irq_pend = 8'h10; cyc(3);
    chk("R7 not enabled", pll_en, 1'b0);
    irq_pend = '0; cyc(1);

    // R7 sweep interrupt bits in software standby
    for (int b = 0; b < IRQ_W; b++) begin
      logic exp_w;
      exp_w = !NOWAKE[b];
      irq_pend = 8'(1 << b); irq_en = 8'(1 << b);
      cyc(3);
      chk($sformatf("R7 bit%0d", b), pll_en, exp_w);
      irq_pend = '0; irq_en = '0;
      if (exp_w) begin
        cyc(SETTLE + 2);
        chk("R7 rst stays", cpu_rst_n, 1'b1);
        strobe_stby();
      end
    end

    // R7 wakeup pin leaves software standby
    full_wake();
    chk("R7 pin wake", cpu_clk_en, 1'b1);
    strobe_stby();

    // R13 keyboard wake gating in software standby
    kbd_six_col = 1'b1; kbd_col = 8'h01; cyc(4);
    chk("R12 kbd irq", kbd_irq, 1'b1);
    chk("R13 masked", pll_en, 1'b0);
    kbd_direct_wake = 1'b1; cyc(3);
    chk("R13 direct", pll_en, 1'b1);
    kbd_col = '0; kbd_direct_wake = 1'b0; cyc(SETTLE + 2);
    strobe_stby();
    kbd_irq_en = 1'b1; kbd_col = 8'h02; cyc(3);
    chk("R13 enabled", pll_en, 1'b1);
    kbd_col = '0; cyc(SETTLE + 2);
    strobe_halt();
    kbd_col = 8'h04; cyc(3);
    chk("R13 idle", cpu_clk_en, 1'b1);
    kbd_col = '0; kbd_irq_en = 1'b0; cyc(2);

    // R12 column sweep in both modes
    for (int c = 0; c < 8; c++) begin
      kbd_six_col = 1'b1; kbd_col = 8'(1 << c); cyc(2);
      chk($sformatf("R12 six col%0d", c), kbd_irq, c < 6);
      kbd_col = '0; cyc(2);
      kbd_six_col = 1'b0; kbd_col = 8'(1 << c); cyc(1);
      chk($sformatf("R12 deb early col%0d", c), kbd_irq, 1'b0);
      cyc((KDEB + 1) * TPER);
      chk($sformatf("R12 deb col%0d", c), kbd_irq, 1'b1);
      kbd_col = '0; cyc(2);
      chk($sformatf("R12 release col%0d", c), kbd_irq, 1'b0);
    end
    chk("R12 oper kept", cpu_clk_en, 1'b1);

    // R5 power fail from Operating, user reset from Idle
    power_fail = 1'b1; cyc(1); power_fail = 1'b0; cyc(1);
    chk("R5 pf run", run, 1'b0);
    chk("R5 pf rst", cpu_rst_n, 1'b0);
    full_wake();
    strobe_halt();
    strobe_ureset();
    chk("R5 idle ureset", run, 1'b0);
    chk("R5 idle rst", cpu_rst_n, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule